// File: doc/BRIEF.md
# Sticky Instruction-Armed Watchdog

This block is the watchdog of a small microcontroller core. The instruction decoder pulses a one-cycle strobe each time the watchdog instruction (opcode 5F hex) executes. That one strobe does two jobs. The first strobe after a device reset arms the watchdog, and every later strobe refreshes it. Once armed, no instruction can disarm it. Only the device reset input, or the watchdog's own reset request, returns it to the idle state.

While armed, the block counts down a free-running tick enable from a reload value. If the software lets a full period of ticks pass without a strobe, the block raises a system reset request for a fixed number of clock cycles. Each watchdog instruction also updates three status flags of the core. The block drives a write mask and a write value so that the core's flag register changes only the zero, sign and overflow bits. The flag register itself, the clock source and power-on reset generation are outside this block.

All pins are plain control and status signals. None carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sticky_wdog`

## Requirements
- R1: While `rst_n` is low and right after it rises, `sys_rst_req` is 0, the watchdog is disarmed and `flag_we` is 0.
- R2: Before the first `refresh_op` strobe after reset, `sys_rst_req` never rises, however many ticks arrive. A strobe sampled while disarmed and while `sys_rst_req` is low arms the watchdog.
- R3: Every accepted strobe reloads the counter to `PERIOD_TICKS`. A tick in the strobe cycle does not count. `sys_rst_req` first reads high after the clock edge that samples the `PERIOD_TICKS`-th tick after the last strobe.
- R4: Once armed, further strobes only refresh the watchdog. No strobe pattern disarms it.
- R5: Cycles with `tick` low do not change the counter, so the timeout is counted in ticks, not clock cycles.
- R6: A strobe sampled in the same cycle as the final tick of a period wins. No request is raised, and a new full period starts.
- R7: `sys_rst_req` stays high for exactly `RST_CYCLES` consecutive cycles. It disarms the watchdog and clears the counter. Afterwards no further request arises until a new strobe.
- R8: A strobe sampled while `sys_rst_req` is high does not arm the watchdog.
- R9: In every cycle where `refresh_op` is high, `flag_we` is 8'h70 (bit 6 = Z, bit 5 = S, bit 4 = V) and `flag_wdata` is 8'h40 (Z=1, S=0, V=0, all other bits 0). In all other cycles both are 0.
- R10: Pulling `rst_n` low while the watchdog is armed disarms it. After release, no request arises without a new strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| refresh_op | input | 1 | One-cycle strobe: the watchdog instruction executes |
| tick | input | 1 | Free-running timebase enable, one pulse per tick |
| sys_rst_req | output | 1 | System reset request, high for RST_CYCLES cycles |
| flag_we | output | 8 | Flag register write mask (Z, S, V bits) |
| flag_wdata | output | 8 | Flag register write value |

## Verification
The bench builds the block with `PERIOD_TICKS` = 5 and `RST_CYCLES` = 3. With these values, a full timeout, the whole request pulse and the edge where a refresh coincides with the final tick all occur within a few dozen cycles. The short period also lets the bench check the exact expiry edge under a held and a gated tick, drive a strobe into the middle of the request pulse, and drop reset halfway through a period in a single short run.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int FLAG_W = 8;
  localparam int Z_POS  = 6;
  localparam int S_POS  = 5;
  localparam int V_POS  = 4;

  // Mask of the flag bits the watchdog instruction writes.
  function automatic logic [FLAG_W-1:0] zsv_mask();
    logic [FLAG_W-1:0] m;
    m = '0;
    m[Z_POS] = 1'b1;
    m[S_POS] = 1'b1;
    m[V_POS] = 1'b1;
    return m;
  endfunction

  // Value written under the mask: Z set, S and V cleared.
  function automatic logic [FLAG_W-1:0] zsv_value();
    logic [FLAG_W-1:0] v;
    v = '0;
    v[Z_POS] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/swd_arm.sv
module swd_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_ok,
  input  logic drop,
  output logic armed
);
  // Sticky enable: set by an accepted strobe, cleared only by reset or expiry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (drop)       armed <= 1'b0;
    else if (refresh_ok) armed <= 1'b1;
  end
endmodule

// File: rtl/swd_count.sv
module swd_count #(
  parameter int PERIOD_TICKS = 4096,
  localparam int CW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          armed,
  input  logic          tick,
  input  logic          clear,
  output logic          expire,
  output logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] RELOAD_VAL = CW'(PERIOD_TICKS);
  localparam logic [CW-1:0] LAST_VAL   = CW'(1);

  logic step;
  assign step   = armed && tick && (cnt_q != '0);
  // Expiry: the tick that would empty the counter, unless a refresh wins.
  assign expire = step && (cnt_q == LAST_VAL) && !reload && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (reload) cnt_q <= RELOAD_VAL;
    else if (step)   cnt_q <= cnt_q - LAST_VAL;
  end
endmodule

// File: rtl/swd_pulse.sv
module swd_pulse #(
  parameter int RST_CYCLES = 16,
  localparam int PW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam logic [PW-1:0] LEN = PW'(RST_CYCLES);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (fire)          left_q <= LEN;
    else if (left_q != '0)  left_q <= left_q - PW'(1);
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/swd_flags.sv
module swd_flags
  import swd_pkg::*;
(
  input  logic              refresh_op,
  output logic [FLAG_W-1:0] flag_we,
  output logic [FLAG_W-1:0] flag_wdata
);
  always_comb begin
    flag_we    = '0;
    flag_wdata = '0;
    if (refresh_op) begin
      flag_we    = zsv_mask();
      flag_wdata = zsv_value();
    end
  end
endmodule

// File: rtl/sticky_wdog.sv
module sticky_wdog #(
  parameter int PERIOD_TICKS = 4096,
  parameter int RST_CYCLES   = 16,
  localparam int CW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refresh_op,
  input  logic       tick,
  output logic       sys_rst_req,
  output logic [7:0] flag_we,
  output logic [7:0] flag_wdata
);
  logic          armed_q;
  logic          expire;
  logic          refresh_ok;
  logic [CW-1:0] cnt_q;

  // Strobes are ignored while the reset request is high.
  assign refresh_ok = refresh_op && !sys_rst_req;

  swd_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .refresh_ok (refresh_ok),
    .drop       (expire || sys_rst_req),
    .armed      (armed_q)
  );

  swd_count #(.PERIOD_TICKS(PERIOD_TICKS)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (refresh_ok),
    .armed  (armed_q),
    .tick   (tick),
    .clear  (sys_rst_req),
    .expire (expire),
    .cnt_q  (cnt_q)
  );

  swd_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (expire),
    .active (sys_rst_req)
  );

  swd_flags u_flags (
    .refresh_op (refresh_op),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata)
  );
endmodule

// File: rtl/swd_chk.sv
module swd_chk #(
  parameter int PERIOD_TICKS = 4096,
  parameter int RST_CYCLES   = 16,
  localparam int CW = $clog2(PERIOD_TICKS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          refresh_op,
  input logic          tick,
  input logic          sys_rst_req,
  input logic [7:0]    flag_we,
  input logic [7:0]    flag_wdata,
  input logic          armed_q,
  input logic [CW-1:0] cnt_q
);
  int hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_run <= 0;
    else if (sys_rst_req) hi_run <= hi_run + 1;
    else                  hi_run <= 0;
  end

  // R2
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(armed_q));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PERIOD_TICKS));
  // R5
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !refresh_op && !sys_rst_req) |=> $stable(cnt_q));
  // R6
  refresh_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_op && !sys_rst_req) |=> !sys_rst_req);
  // R7
  req_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !armed_q);
  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> hi_run == RST_CYCLES);
  // R7
  pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> hi_run < RST_CYCLES);
  // R9
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we != 8'h00) |-> refresh_op);
  // R9
  flag_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_op |-> (flag_wdata[6] && !flag_wdata[5] && !flag_wdata[4]));
endmodule

bind sticky_wdog swd_chk #(.PERIOD_TICKS(PERIOD_TICKS), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .refresh_op  (refresh_op),
  .tick        (tick),
  .sys_rst_req (sys_rst_req),
  .flag_we     (flag_we),
  .flag_wdata  (flag_wdata),
  .armed_q     (armed_q),
  .cnt_q       (cnt_q)
);

// File: tb/sticky_wdog_bench.sv
module sticky_wdog_bench;
  localparam int P = 5;
  localparam int R = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_op = 1'b0;
  logic tick = 1'b0;
  logic sys_rst_req;
  logic [7:0] flag_we, flag_wdata;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int exp_rise[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sticky_wdog #(.PERIOD_TICKS(P), .RST_CYCLES(R)) u_sticky_wdog (
    .clk(clk), .rst_n(rst_n), .refresh_op(refresh_op), .tick(tick),
    .sys_rst_req(sys_rst_req), .flag_we(flag_we), .flag_wdata(flag_wdata));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: one strobe; optionally pushes the edge at which the request must rise.
  task automatic do_refresh(input bit expect_fire);
    @(negedge clk);
    refresh_op = 1'b1;
    if (expect_fire) exp_rise.push_back(cyc + 1 + P);
    @(negedge clk);
    refresh_op = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: samples 1 ns after each edge.
  bit prev_req = 1'b0;
  int run = 0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        check(sys_rst_req == 1'b0, "R10", sys_rst_req, 0);
      end
      // R9 flag outputs
      check(flag_we == (refresh_op ? 8'h70 : 8'h00), "R9 we", flag_we, refresh_op ? 8'h70 : 0);
      check(flag_wdata == (refresh_op ? 8'h40 : 8'h00), "R9 wdata", flag_wdata, refresh_op ? 8'h40 : 0);
      if (sys_rst_req && !prev_req) begin
        if (exp_rise.size() == 0) begin
          check(1'b0, "R2/R7/R8 unexpected request", cyc, -1);
        end else begin
          int e;
          e = exp_rise.pop_front();
          check(cyc == e, "R3 rise edge", cyc, e);
        end
        run = 1;
      end else if (sys_rst_req) begin
        run++;
      end else if (prev_req) begin
        check(run == R, "R7 pulse length", run, R);
        run = 0;
      end
      prev_req = sys_rst_req;
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    check(1'b0, "watchdog", wd, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick = 1'b1;
    idle(3);
    // R1 reset state
    check(sys_rst_req == 1'b0, "R1 req", sys_rst_req, 0);
    check(flag_we == 8'h00, "R1 we", flag_we, 0);
    @(negedge clk) rst_n = 1'b1;
    // R2: ticks while disarmed raise nothing
    idle(20);
    check(sys_rst_req == 1'b0, "R2 idle", sys_rst_req, 0);

    // R3: single strobe, ticks every cycle
    do_refresh(1'b1);
    idle(P + R + 4);

    // R4: periodic refresh keeps it alive, then it expires
    for (int i = 0; i < 8; i++) begin
      do_refresh(1'b0);
      idle(P - 3);
    end
    do_refresh(1'b1);
    idle(P + R + 4);

    // R6: strobe on the final tick wins
    do_refresh(1'b0);
    idle(P - 2);
    do_refresh(1'b1);
    idle(P + R + 4);

    // R5: ticks held low freeze the count
    @(negedge clk) tick = 1'b0;
    do_refresh(1'b0);
    idle(10);
    check(sys_rst_req == 1'b0, "R5 frozen", sys_rst_req, 0);
    @(negedge clk);
    tick = 1'b1;
    exp_rise.push_back(cyc + 1 + P - 1);
    idle(P + R + 4);

    // R8: strobe during request is ignored, R7: no request afterwards
    do_refresh(1'b1);
    while (!sys_rst_req) @(negedge clk);
    do_refresh(1'b0);
    idle(P + R + 10);
    check(sys_rst_req == 1'b0, "R8 stays disarmed", sys_rst_req, 0);

    // R10: device reset while armed
    do_refresh(1'b0);
    idle(2);
    @(negedge clk) rst_n = 1'b0;
    idle(2);
    @(negedge clk) rst_n = 1'b1;
    idle(P + 10);
    check(sys_rst_req == 1'b0, "R10 disarmed", sys_rst_req, 0);

    check(exp_rise.size() == 0, "R3 missing request", exp_rise.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule